// File: doc/BRIEF.md
# Synchronous Serial Master Transmitter-Receiver

This block is a master-only synchronous serial port for fixed-width characters. Clock polarity is 0 and phase is 0, so the serial clock rests low. A write from the register bus lands either straight in the shift register, when the port is idle, or in a one-deep holding buffer, when a character is already in flight. A reload-based tick generator emits one tick per half bit period. Every tick moves the serial clock one half cycle. Data leaves most significant bit first, and the incoming line is sampled on each rising clock edge.

Three status flags report progress. The buffer-free flag says the port can take another write. The receive-done flag says a full character has been collected. The busy flag is high while a character occupies the serial lines. Their timing follows fixed rules relative to the half-bit ticks, as listed below. Software clears the two request flags by writing 1 to a dedicated input for each. Dropping the enable aborts any character and parks the lines.

Top module: `ssc_master`

## Requirements
- R1: After reset the serial clock, serial data out, buffer-free flag, receive-done flag, busy flag and received character are all 0.
- R2: A write accepted while the port is idle and enabled sets the buffer-free flag on the clock edge that completes the write, for any reload value. Busy is still 0 at that point.
- R3: After such a write, busy rises on the first tick that follows the write, which is 1 to reload+1 clocks later. At that moment the clock is low and the data line already carries the most significant bit.
- R4: Ticks come every reload+1 clocks. While busy, each tick toggles the serial clock. The first rise comes one tick after busy rises, and a character has exactly 8 rising edges spaced two ticks apart. The data line advances one bit, most significant first, on each falling edge.
- R5: Serial data in is sampled on each rising edge, first bit into the most significant position. The receive-done flag sets, and the received character updates, on the 8th rising edge.
- R6: With nothing pending, busy falls one tick after the 8th rising edge, together with the clock returning low. The serial clock is never high while busy is low, and the data line is 0 while idle.
- R7: A write made while a character is in flight does not set the buffer-free flag at once. The flag sets on the last rising edge of the current character, in the same cycle as receive-done. The buffered character starts on the very next tick, and busy stays high across the boundary.
- R8: A 1 on either clear input clears its flag on the next edge. If the flag is set in the same cycle, the set wins.
- R9: While enable is 0, ticks stop, writes are ignored (no flag change, no busy), and an ongoing character is abandoned, with busy, serial clock and data line at 0 on the next edge.
- R10: A second write while the holding buffer is already full replaces the pending character. Only the newest one is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| en | input | 1 | Port enable |
| reload | input | RELOAD_W | Half-bit period minus one, in clocks |
| wr | input | 1 | Transmit write strobe |
| wdata | input | CHAR_W | Character to send |
| clr_tir | input | 1 | Write-1-to-clear for buffer-free flag |
| clr_rir | input | 1 | Write-1-to-clear for receive-done flag |
| sdi | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data out |
| tir | output | 1 | Buffer-free request flag |
| rir | output | 1 | Receive-done request flag |
| busy | output | 1 | Character in progress |
| rx_data | output | CHAR_W | Last received character |

## Verification
The bench targets the busy lag after an idle write. A design that raised busy on the write itself, instead of on the next tick, would show busy in the same cycle as the buffer-free flag. Back-to-back characters check that the buffer-free flag coincides with receive-done and that busy never dips; an early flag or a one-tick gap between characters shows up at once. Overwriting a full buffer, a clear that collides with a set, writes while disabled, and an enable drop mid-character each have their own check, alongside a per-cycle comparison of every output against a behavioural model.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } eng_state_t;

  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned FLAG_TIR  = 0;
  localparam int unsigned FLAG_RIR  = 1;
endpackage

// File: rtl/ssc_baud.sv
module ssc_baud #(
  parameter int unsigned RELOAD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [RELOAD_W-1:0] reload,
  output logic                tick
);

  logic [RELOAD_W-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!en || (cnt_q == '0)) begin
      cnt_d = reload;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (reload != '0)) |=> !tick); // R4

endmodule

// File: rtl/ssc_engine.sv
module ssc_engine
  import ssc_pkg::*;
#(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              wr,
  input  logic [CHAR_W-1:0] wdata,
  input  logic              sdi,
  output logic              sclk,
  output logic              sdo,
  output logic              busy,
  output logic              idle,
  output logic [CHAR_W-1:0] rx_data,
  output logic              ev_tir,
  output logic              ev_rir
);

  localparam int unsigned STEP_W = $clog2(2 * CHAR_W + 1);
  localparam logic [STEP_W-1:0] LAST_RISE = STEP_W'(2 * CHAR_W - 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(2 * CHAR_W);

  eng_state_t        st_q, st_d;
  logic [CHAR_W-1:0] tx_q, tx_d;
  logic [CHAR_W-1:0] rsh_q, rsh_d;
  logic [CHAR_W-1:0] buf_q, buf_d;
  logic [CHAR_W-1:0] rxd_q, rxd_d;
  logic              full_q, full_d;
  logic              owed_q, owed_d;
  logic [STEP_W-1:0] step_q, step_d, step_n;
  logic              sclk_q, sclk_d;
  logic              busy_q, busy_d;
  logic              wr_en;

  assign wr_en = wr && en;

  always_comb begin
    st_d   = st_q;
    tx_d   = tx_q;
    rsh_d  = rsh_q;
    buf_d  = buf_q;
    rxd_d  = rxd_q;
    full_d = full_q;
    owed_d = owed_q;
    step_d = step_q;
    sclk_d = sclk_q;
    busy_d = busy_q;
    ev_tir = 1'b0;
    ev_rir = 1'b0;
    step_n = step_q + 1'b1;

    if (!en) begin
      st_d   = ST_IDLE;
      full_d = 1'b0;
      owed_d = 1'b0;
      step_d = '0;
      sclk_d = 1'b0;
      busy_d = 1'b0;
    end else begin
      if (wr_en) begin
        if (st_q == ST_IDLE) begin
          tx_d   = wdata;
          st_d   = ST_ARMED;
          ev_tir = 1'b1;
        end else begin
          buf_d  = wdata;
          full_d = 1'b1;
          owed_d = 1'b1;
        end
      end
      if (tick) begin
        case (st_q)
          ST_ARMED: begin
            st_d   = ST_RUN;
            busy_d = 1'b1;
            step_d = '0;
          end
          ST_RUN: begin
            step_d = step_n;
            if (step_n[0]) begin
              sclk_d = 1'b1;
              rsh_d  = {rsh_q[CHAR_W-2:0], sdi};
              if (step_n == LAST_RISE) begin
                rxd_d  = {rsh_q[CHAR_W-2:0], sdi};
                ev_rir = 1'b1;
                if (owed_d) begin
                  ev_tir = 1'b1;
                  owed_d = 1'b0;
                end
              end
            end else begin
              sclk_d = 1'b0;
              if (step_n == LAST_STEP) begin
                if (full_d) begin
                  tx_d   = buf_d;
                  full_d = 1'b0;
                  step_d = '0;
                  if (owed_d) begin
                    ev_tir = 1'b1;
                    owed_d = 1'b0;
                  end
                end else begin
                  busy_d = 1'b0;
                  st_d   = ST_IDLE;
                end
              end else begin
                tx_d = {tx_q[CHAR_W-2:0], 1'b0};
              end
            end
          end
          default: begin
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tx_q   <= '0;
      rsh_q  <= '0;
      buf_q  <= '0;
      rxd_q  <= '0;
      full_q <= 1'b0;
      owed_q <= 1'b0;
      step_q <= '0;
      sclk_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tx_q   <= tx_d;
      rsh_q  <= rsh_d;
      buf_q  <= buf_d;
      rxd_q  <= rxd_d;
      full_q <= full_d;
      owed_q <= owed_d;
      step_q <= step_d;
      sclk_q <= sclk_d;
      busy_q <= busy_d;
    end
  end

  assign sclk    = sclk_q;
  assign busy    = busy_q;
  assign idle    = (st_q == ST_IDLE);
  assign sdo     = idle ? 1'b0 : tx_q[CHAR_W-1];
  assign rx_data = rxd_q;

  AST_SCLK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sclk_q); // R6

  AST_SCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && en && !tick) |=> $stable(sclk_q)); // R4

  AST_OFF_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy_q && !sclk_q)); // R9

endmodule

// File: rtl/ssc_flags.sv
module ssc_flags
  import ssc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] set,
  input  logic [NUM_FLAGS-1:0] clr,
  output logic [NUM_FLAGS-1:0] flag
);

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic q, d;

    always_comb begin
      d = q;
      if (set[i]) begin
        d = 1'b1;
      end else if (clr[i]) begin
        d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= 1'b0;
      end else begin
        q <= d;
      end
    end

    assign flag[i] = q;

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !flag[i]); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flag[i]); // R8
  end

endmodule

// File: rtl/ssc_master.sv
module ssc_master
  import ssc_pkg::*;
#(
  parameter int unsigned CHAR_W   = 8,
  parameter int unsigned RELOAD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                wr,
  input  logic [CHAR_W-1:0]   wdata,
  input  logic                clr_tir,
  input  logic                clr_rir,
  input  logic                sdi,
  output logic                sclk,
  output logic                sdo,
  output logic                tir,
  output logic                rir,
  output logic                busy,
  output logic [CHAR_W-1:0]   rx_data
);

  logic                 tick;
  logic                 eng_idle;
  logic                 ev_tir, ev_rir;
  logic [NUM_FLAGS-1:0] fl_set, fl_clr, fl_q;

  ssc_baud #(.RELOAD_W(RELOAD_W)) i_baud (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .reload (reload),
    .tick   (tick)
  );

  ssc_engine #(.CHAR_W(CHAR_W)) i_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .tick    (tick),
    .wr      (wr),
    .wdata   (wdata),
    .sdi     (sdi),
    .sclk    (sclk),
    .sdo     (sdo),
    .busy    (busy),
    .idle    (eng_idle),
    .rx_data (rx_data),
    .ev_tir  (ev_tir),
    .ev_rir  (ev_rir)
  );

  always_comb begin
    fl_set           = '0;
    fl_clr           = '0;
    fl_set[FLAG_TIR] = ev_tir;
    fl_set[FLAG_RIR] = ev_rir;
    fl_clr[FLAG_TIR] = clr_tir;
    fl_clr[FLAG_RIR] = clr_rir;
  end

  ssc_flags i_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (fl_set),
    .clr   (fl_clr),
    .flag  (fl_q)
  );

  assign tir = fl_q[FLAG_TIR];
  assign rir = fl_q[FLAG_RIR];

  AST_TIR_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && en && eng_idle) |=> (tir && !busy)); // R2

  AST_OFF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !tir) |=> !tir); // R9

endmodule

// File: tb/test_ssc_master.sv
module test_ssc_master;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, en, wr, clr_tir, clr_rir, sdi_inv;
  logic [7:0] reload, wdata;
  logic       sdi, sclk, sdo, tir, rir, busy;
  logic [7:0] rx_data;

  int n_chk, n_bad, cyc;

  assign sdi = sdo ^ sdi_inv;

  ssc_master i_ssc_master (
    .clk(clk), .rst_n(rst_n), .en(en), .reload(reload), .wr(wr), .wdata(wdata),
    .clr_tir(clr_tir), .clr_rir(clr_rir), .sdi(sdi), .sclk(sclk), .sdo(sdo),
    .tir(tir), .rir(rir), .busy(busy), .rx_data(rx_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // behavioural reference model
  int m_cnt, m_k, m_bit, m_tx, m_pend, m_rxacc, m_rx;
  bit m_armed, m_busy, m_owed, m_sclk, m_tir, m_rir;

  function automatic int m_sdo();
    if (!m_armed && !m_busy) return 0;
    return (m_tx >> (7 - m_bit)) & 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_k = 0; m_bit = 0; m_tx = 0; m_pend = -1; m_rxacc = 0; m_rx = 0;
      m_armed = 0; m_busy = 0; m_owed = 0; m_sclk = 0; m_tir = 0; m_rir = 0;
    end else begin
      bit tk, was_armed, stir, srir;
      tk = en && (m_cnt == 0);
      if (!en || m_cnt == 0) m_cnt = int'(reload); else m_cnt = m_cnt - 1;
      stir = 0; srir = 0; was_armed = m_armed;
      if (!en) begin
        m_armed = 0; m_busy = 0; m_sclk = 0; m_pend = -1; m_owed = 0; m_k = 0;
      end else begin
        if (wr) begin
          if (!m_armed && !m_busy) begin
            m_tx = int'(wdata); m_bit = 0; m_armed = 1; stir = 1;
          end else begin
            m_pend = int'(wdata); m_owed = 1;
          end
        end
        if (tk && m_busy) begin
          m_k++;
          if (m_k % 2 == 1) begin
            m_sclk = 1;
            m_rxacc = ((m_rxacc << 1) | int'(sdi)) & 255;
            if (m_k == 15) begin
              m_rx = m_rxacc; srir = 1;
              if (m_owed) begin stir = 1; m_owed = 0; end
            end
          end else begin
            m_sclk = 0;
            if (m_k == 16) begin
              if (m_pend >= 0) begin
                m_tx = m_pend; m_pend = -1; m_bit = 0; m_k = 0;
                if (m_owed) begin stir = 1; m_owed = 0; end
              end else begin
                m_busy = 0;
              end
            end else begin
              m_bit++;
            end
          end
        end else if (tk && was_armed) begin
          m_armed = 0; m_busy = 1; m_k = 0;
        end
      end
      m_tir = stir ? 1'b1 : (clr_tir ? 1'b0 : m_tir);
      m_rir = srir ? 1'b1 : (clr_rir ? 1'b0 : m_rir);
    end
  end

  // per-cycle comparison and watchdog
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R4", int'(sclk), int'(m_sclk), "model sclk");
      chk("R4", int'(sdo), m_sdo(), "model sdo");
      chk("R3", int'(busy), int'(m_busy), "model busy");
      chk("R2", int'(tir), int'(m_tir), "model tir");
      chk("R5", int'(rir), int'(m_rir), "model rir");
      chk("R5", int'(rx_data), m_rx, "model rx_data");
    end
    if (cyc > 60000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired, all requirements affected actual=%0d expected=%0d", cyc, 60000);
      wrap_up();
    end
  end

  task automatic put(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic clr_both();
    @(negedge clk); clr_tir = 1'b1; clr_rir = 1'b1;
    @(negedge clk); clr_tir = 1'b0; clr_rir = 1'b0;
  endtask

  task automatic pulse_clr_rir();
    @(negedge clk); clr_rir = 1'b1;
    @(negedge clk); clr_rir = 1'b0;
  endtask

  task automatic wait_for(input bit want_busy, input bit use_rir);
    int n;
    n = 0;
    while (((use_rir ? rir : busy) != want_busy) && n < 2000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic xfer_check(input logic [7:0] d, input logic [7:0] exp_rx);
    int n, rises, last;
    logic prev;
    clr_both();
    put(d);
    chk("R2", int'(tir), 1, "tir right after idle write");
    chk("R2", int'(busy), 0, "busy right after idle write");
    n = 0;
    while (!busy && n < 300) begin @(negedge clk); n++; end
    chk("R3", int'(n >= 1 && n <= int'(reload) + 1), 1, "busy lag within one tick");
    chk("R3", int'(sclk), 0, "sclk low at busy rise");
    chk("R3", int'(sdo), int'(d[7]), "msb out before first edge");
    rises = 0; last = 0; n = 0; prev = 1'b0;
    while (!rir && n < 3000) begin
      @(negedge clk); n++;
      if (sclk && !prev) begin
        rises++;
        chk("R4", n - last, (rises == 1) ? int'(reload) + 1 : 2 * (int'(reload) + 1), "rise spacing");
        last = n;
      end
      prev = sclk;
    end
    chk("R4", rises, 8, "rising edges per char");
    chk("R5", int'(rx_data), int'(exp_rx), "received char");
    chk("R5", int'(busy), 1, "busy at receive-done");
    n = 0;
    while (busy && n < 300) begin @(negedge clk); n++; end
    chk("R6", n, int'(reload) + 1, "busy fall delay after last rise");
    chk("R6", int'(sclk), 0, "sclk low after char");
    chk("R6", int'(sdo), 0, "sdo low when idle");
  endtask

  initial begin
    int drops;
    n_chk = 0; n_bad = 0; cyc = 0;
    rst_n = 1'b0; en = 1'b0; wr = 1'b0; wdata = '0; clr_tir = 1'b0; clr_rir = 1'b0;
    sdi_inv = 1'b0; reload = 8'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(sclk), 0, "reset sclk");
    chk("R1", int'(sdo), 0, "reset sdo");
    chk("R1", int'(tir) + int'(rir) + int'(busy), 0, "reset flags");
    chk("R1", int'(rx_data), 0, "reset rx_data");

    en = 1'b1;
    repeat (5) @(negedge clk);
    xfer_check(8'hA5, 8'hA5);
    reload = 8'd1;
    sdi_inv = 1'b1;
    xfer_check(8'h3B, 8'hC4);
    sdi_inv = 1'b0;
    reload = 8'd3;

    // R7 back-to-back
    clr_both();
    put(8'h3C);
    wait_for(1'b1, 1'b0);
    clr_both();
    put(8'hC3);
    chk("R7", int'(tir), 0, "no early tir while busy");
    wait_for(1'b1, 1'b1);
    chk("R7", int'(tir), 1, "tir with receive-done");
    chk("R7", int'(rx_data), 8'h3C, "first char");
    pulse_clr_rir();
    drops = 0;
    for (int i = 0; i < 2000 && !rir; i++) begin
      @(negedge clk);
      if (!busy) drops++;
    end
    chk("R7", drops, 0, "busy gaps between chars");
    chk("R7", int'(rx_data), 8'hC3, "second char");
    wait_for(1'b0, 1'b0);

    // R10 overwrite of pending buffer
    reload = 8'd0;
    clr_both();
    put(8'h11); put(8'h22); put(8'h33);
    wait_for(1'b1, 1'b1);
    chk("R10", int'(rx_data), 8'h11, "first of overwrite run");
    pulse_clr_rir();
    wait_for(1'b1, 1'b1);
    chk("R10", int'(rx_data), 8'h33, "newest pending sent");
    wait_for(1'b0, 1'b0);
    repeat (20) @(negedge clk);
    chk("R10", int'(busy), 0, "no third char");

    // R8 clear and set-wins
    pulse_clr_rir();
    chk("R8", int'(rir), 0, "rir cleared");
    @(negedge clk); clr_tir = 1'b1;
    @(negedge clk); clr_tir = 1'b0;
    chk("R8", int'(tir), 0, "tir cleared");
    @(negedge clk); wr = 1'b1; wdata = 8'h5A; clr_tir = 1'b1;
    @(negedge clk); wr = 1'b0; clr_tir = 1'b0;
    chk("R8", int'(tir), 1, "set beats clear");
    wait_for(1'b0, 1'b0);

    // R9 disabled
    reload = 8'd2;
    en = 1'b0;
    clr_both();
    put(8'h77);
    chk("R9", int'(tir), 0, "write ignored while off");
    repeat (20) @(negedge clk);
    chk("R9", int'(busy), 0, "no busy while off");
    chk("R9", int'(sclk), 0, "no clock while off");
    en = 1'b1;
    put(8'hF0);
    wait_for(1'b1, 1'b0);
    for (int i = 0; i < 100 && !sclk; i++) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R9", int'(busy), 0, "abort busy");
    chk("R9", int'(sclk), 0, "abort sclk");
    chk("R9", int'(sdo), 0, "abort sdo");
    en = 1'b1;
    repeat (4) @(negedge clk);
    xfer_check(8'h96, 8'h96);

    wrap_up();
  end
endmodule